// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the execution half of a simple processor. Four general registers, a program counter, an instruction register, a memory address register, a memory data register, a hidden operand register and a hidden result register all hang on one internal 16-bit bus. An external sequencer supplies a control word every cycle. The control word holds a per-register output enable, a per-register input enable, the ALU operation, a clear for the operand register, a carry-in bit, and read and write request bits.

The arithmetic unit takes its first operand from the hidden operand register, or zero when that register is cleared, and its second operand from the bus. It places its result only in the hidden result register. From there the result must be driven back over the bus to reach its destination. A register-to-register add therefore takes three bus steps.

Memory traffic uses a request/completion handshake. An accepted read or write request stays asserted, with a stable address taken from the address register, until the memory raises its done signal. While one request is outstanding the datapath accepts no new request, which is the only form of back-pressure at this edge. The sequencer must wait for the request lines to drop before it issues the next one.

Top module: `sbus_datapath`

## Requirements
- R1: After reset every register reads zero, `bus_o` is zero, `bus_err` is low and neither `mem_rd` nor `mem_wr` is asserted.
- R2: Register indices are 0–3 for R0–R3, 4 for PC, 5 for IR, 6 for MAR, 7 for MDR, 8 for Y and 9 for Z. When exactly one bit of `out_en` is set, `bus_o` equals that register's value in the same cycle. When no bit is set, `bus_o` is zero.
- R3: When two or more bits of `out_en` are set, `bus_err` is high and `bus_o` is zero. Any loads taken in that cycle receive zero.
- R4: Each register 0–8 whose `in_en` bit is set loads `bus_o` at the clock edge, and several may load in the same cycle. Registers whose bit is clear keep their value.
- R5: When `in_en[9]` is set, Z loads the ALU result. The ALU's first operand A is 0 if `clear_y` is set and Y otherwise. With `alu_sub`=0 the result is A + bus + `carry_in`. With `alu_sub`=1 the result is A − bus and `carry_in` is ignored. Z is unchanged when `in_en[9]` is clear.
- R6: A `rd_cmd` accepted while no request is outstanding asserts `mem_rd` from the next cycle. `mem_rd` stays asserted through the cycle in which `mem_done` is seen and drops after it. `mem_addr` always equals MAR.
- R7: In the cycle that completes a read, MDR loads `mem_rdata`, and this takes priority over a bus load of MDR in the same cycle.
- R8: A `wr_cmd` accepted while no request is outstanding asserts `mem_wr` until `mem_done`, with the same timing as R6. `mem_wdata` always equals MDR.
- R9: Requests arriving while one is outstanding are dropped. If `rd_cmd` and `wr_cmd` arrive together, the read is taken and the write is dropped. `mem_rd` and `mem_wr` are never both high.
- R10: `mem_done` with no outstanding request changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_en | input | 10 | Bus drive enable per register |
| in_en | input | 10 | Load enable per register (bit 9 loads Z from the ALU) |
| alu_sub | input | 1 | 0 add, 1 subtract |
| clear_y | input | 1 | Replace Y by zero at the ALU input |
| carry_in | input | 1 | Adds 1 to an add |
| rd_cmd | input | 1 | Memory read request |
| wr_cmd | input | 1 | Memory write request |
| mem_addr | output | 16 | Word address (MAR) |
| mem_wdata | output | 16 | Write data (MDR) |
| mem_rd | output | 1 | Read outstanding |
| mem_wr | output | 1 | Write outstanding |
| mem_rdata | input | 16 | Read data, valid with mem_done |
| mem_done | input | 1 | Memory completion |
| bus_o | output | 16 | Current internal bus value |
| bus_err | output | 1 | More than one bus driver requested |

## Verification
The handshake assertions assume the memory raises `mem_done` only while a request is outstanding, or spuriously when the data is ignored. They also assume `mem_rdata` is meaningful only in a completing read cycle. The bench memory answers only outstanding requests, with a latency that rotates from zero to three cycles. It injects stray completions only while it is idle, which exercises R10 without violating those assumptions. The random phase also drives bus conflicts and overlapping requests, and a behavioural model predicts their outcomes.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int WORD_W = 16;
  localparam int NUM_SRC = 10;
  localparam int NUM_GPR = 6;
  typedef enum logic [3:0] {
    S_R0, S_R1, S_R2, S_R3, S_PC, S_IR, S_MAR, S_MDR, S_Y, S_Z
  } src_e;
endpackage

// File: rtl/sbus_mux.sv
module sbus_mux #(
  parameter int W = 16,
  parameter int N = 10
) (
  input  logic [N-1:0]        oe,
  input  logic [N-1:0][W-1:0] vals,
  output logic [W-1:0]        bus,
  output logic                err
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) begin
      if (oe[i]) bus = bus | vals[i];
    end
    err = ($countones(oe) > 1);
    if (err) bus = '0;
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus,
  input  logic         y_load,
  input  logic         z_load,
  input  logic         clear_y,
  input  logic         carry_in,
  input  logic         sub,
  output logic [W-1:0] y_q,
  output logic [W-1:0] z_q
);
  logic [W-1:0] opa, res;

  always_comb begin
    opa = clear_y ? '0 : y_q;
    if (sub) res = opa - bus;
    else     res = opa + bus + {{(W-1){1'b0}}, carry_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q <= '0;
      z_q <= '0;
    end else begin
      if (y_load) y_q <= bus;
      if (z_load) z_q <= res;
    end
  end

  // R5
  z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !z_load |=> $stable(z_q));
endmodule

// File: rtl/sbus_mem_if.sv
module sbus_mem_if #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus,
  input  logic         mar_load,
  input  logic         mdr_load,
  input  logic         rd_cmd,
  input  logic         wr_cmd,
  input  logic         mem_done,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mar_q,
  output logic [W-1:0] mdr_q,
  output logic         mem_rd,
  output logic         mem_wr
);
  logic busy;
  assign busy = mem_rd | mem_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q  <= '0;
      mdr_q  <= '0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      if (mar_load) mar_q <= bus;
      if (mem_done && mem_rd) mdr_q <= mem_rdata;
      else if (mdr_load)      mdr_q <= bus;
      if (busy) begin
        if (mem_done) begin
          mem_rd <= 1'b0;
          mem_wr <= 1'b0;
        end
      end else if (rd_cmd) begin
        mem_rd <= 1'b1;
      end else if (wr_cmd) begin
        mem_wr <= 1'b1;
      end
    end
  end

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_done |=> mem_rd);
  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_done |=> !mem_rd);
  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !mem_done |=> mem_wr);
  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R7
  mdr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_done |=> mdr_q == $past(mem_rdata));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] out_en,
  input  logic [N-1:0] in_en,
  input  logic         alu_sub,
  input  logic         clear_y,
  input  logic         carry_in,
  input  logic         rd_cmd,
  input  logic         wr_cmd,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_rd,
  output logic         mem_wr,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_done,
  output logic [W-1:0] bus_o,
  output logic         bus_err
);
  localparam int NG = NUM_GPR;

  logic [W-1:0]        gpr_q [NG];
  logic [W-1:0]        mar_q, mdr_q, y_q, z_q;
  logic [N-1:0][W-1:0] vals;

  for (genvar g = 0; g < NG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)        gpr_q[g] <= '0;
      else if (in_en[g]) gpr_q[g] <= bus_o;
    end
  end

  always_comb begin
    vals = '0;
    for (int i = 0; i < NG; i++) vals[i] = gpr_q[i];
    vals[S_MAR] = mar_q;
    vals[S_MDR] = mdr_q;
    vals[S_Y]   = y_q;
    vals[S_Z]   = z_q;
  end

  sbus_mux #(.W(W), .N(N)) u_mux (
    .oe(out_en), .vals(vals), .bus(bus_o), .err(bus_err)
  );

  sbus_alu #(.W(W)) u_alu (
    .clk(clk), .rst_n(rst_n), .bus(bus_o),
    .y_load(in_en[S_Y]), .z_load(in_en[S_Z]),
    .clear_y(clear_y), .carry_in(carry_in), .sub(alu_sub),
    .y_q(y_q), .z_q(z_q)
  );

  sbus_mem_if #(.W(W)) u_mem (
    .clk(clk), .rst_n(rst_n), .bus(bus_o),
    .mar_load(in_en[S_MAR]), .mdr_load(in_en[S_MDR]),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .mem_done(mem_done), .mem_rdata(mem_rdata),
    .mar_q(mar_q), .mdr_q(mdr_q), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_o == '0);
  // R10
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done && !mem_rd && !mem_wr && !in_en[S_MDR] |=> $stable(mdr_q));
endmodule

// File: tb/tb_sbus_datapath.sv
module tb_sbus_datapath;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  out_en = 0, in_en = 0;
  logic        alu_sub = 0, clear_y = 0, carry_in = 0, rd_cmd = 0, wr_cmd = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = 0, bus_o;
  logic        mem_rd, mem_wr, mem_done = 0, bus_err;

  int vectors = 0, errs = 0;
  logic [15:0] m_reg [10];
  logic [15:0] mem [256];
  logic        m_prd = 0, m_pwr = 0, stray = 0;
  int          lat = 0, lat_next = 0;

  always #2 clk = ~clk;

  sbus_datapath dut (.*);

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  function automatic logic [9:0] bit_of(int i);
    return 10'(1) << i;
  endfunction

  task automatic fail(string tag, logic [15:0] act, logic [15:0] exp);
    errs++;
    $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic step();
    logic [15:0] eb, a, newv [10];
    logic ee;
    int n;
    mem_done = 0;
    mem_rdata = 0;
    if ((m_prd || m_pwr) && lat == 0) begin
      mem_done = 1;
      mem_rdata = mem[m_reg[6][7:0]];
    end else if (!m_prd && !m_pwr && stray) begin
      mem_done = 1;
      mem_rdata = 16'hDEAD;
    end
    #1;
    n = $countones(out_en);
    eb = 0;
    for (int i = 0; i < 10; i++) if (n == 1 && out_en[i]) eb = m_reg[i];
    ee = (n > 1);
    vectors++;
    if (bus_o !== eb)       fail(ee ? "R3 bus" : "R2 bus", bus_o, eb);
    if (bus_err !== ee)     fail("R3 err", 16'(bus_err), 16'(ee));
    if (mem_rd !== m_prd)   fail("R6 mem_rd", 16'(mem_rd), 16'(m_prd));
    if (mem_wr !== m_pwr)   fail("R8 mem_wr", 16'(mem_wr), 16'(m_pwr));
    if (mem_addr !== m_reg[6])  fail("R6 mem_addr", mem_addr, m_reg[6]);
    if (mem_wdata !== m_reg[7]) fail("R8 mem_wdata", mem_wdata, m_reg[7]);
    @(posedge clk);
    for (int i = 0; i < 10; i++) newv[i] = m_reg[i];
    for (int i = 0; i < 9; i++) if (in_en[i]) newv[i] = eb;
    if (in_en[9]) begin
      a = clear_y ? 16'h0 : m_reg[8];
      newv[9] = alu_sub ? a - eb : a + eb + 16'(carry_in);
    end
    if (m_prd || m_pwr) begin
      if (mem_done) begin
        if (m_prd) newv[7] = mem_rdata;
        else mem[m_reg[6][7:0]] = m_reg[7];
        m_prd = 0;
        m_pwr = 0;
      end else if (lat > 0) lat--;
    end else if (rd_cmd || wr_cmd) begin
      m_prd = rd_cmd;
      m_pwr = !rd_cmd;
      lat = lat_next;
      lat_next = (lat_next + 1) % 4;
    end
    for (int i = 0; i < 10; i++) m_reg[i] = newv[i];
    @(negedge clk);
  endtask

  task automatic ctl(logic [9:0] oe, logic [9:0] ie, logic sb = 0, logic cy = 0,
                     logic ci = 0, logic rd = 0, logic wr = 0);
    out_en = oe; in_en = ie; alu_sub = sb; clear_y = cy; carry_in = ci;
    rd_cmd = rd; wr_cmd = wr; stray = 0;
    step();
  endtask

  task automatic wait_mem();
    while (m_prd || m_pwr) ctl(0, 0);
  endtask

  task automatic expect_reg(int r, logic [15:0] exp, string tag);
    out_en = bit_of(r); in_en = 0; rd_cmd = 0; wr_cmd = 0; stray = 0;
    #1;
    vectors++;
    if (bus_o !== exp) fail(tag, bus_o, exp);
    step();
  endtask

  // fetch word at PC into register r, PC advances (R4 R5 R6 R7)
  task automatic load_from_pc(int r);
    ctl(bit_of(4), bit_of(6) | bit_of(9), 0, 1, 1, 1);
    ctl(bit_of(9), bit_of(4));
    wait_mem();
    ctl(bit_of(7), bit_of(r));
  endtask

  initial begin
    logic [15:0] v0, v1, v2;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 16'h0105);
    for (int i = 0; i < 10; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 10; i++) expect_reg(i, 16'h0, "R1 reset reg");
    ctl(0, 0);
    // loads through memory: PC 0..3 -> R0..R3
    for (int r = 0; r < 4; r++) load_from_pc(r);
    v0 = mem[0]; v1 = mem[1]; v2 = mem[2];
    expect_reg(0, v0, "R4 R0 load");
    expect_reg(4, 16'd4, "R5 PC increment");
    // R5 add R1+R2 -> R3 in three steps
    ctl(bit_of(1), bit_of(8));
    ctl(bit_of(2), bit_of(9));
    ctl(bit_of(9), bit_of(3));
    expect_reg(3, v1 + v2, "R5 add");
    // R5 subtract R0-R1, carry ignored
    ctl(bit_of(0), bit_of(8));
    ctl(bit_of(1), bit_of(9), 1, 0, 1);
    ctl(bit_of(9), bit_of(2));
    expect_reg(2, v0 - v1, "R5 sub");
    // R3 conflict loads zero
    ctl(bit_of(0) | bit_of(1), bit_of(3));
    expect_reg(3, 16'h0, "R3 conflict load");
    // R8 write R1 to address in R0, then read back
    ctl(bit_of(0), bit_of(6));
    ctl(bit_of(1), bit_of(7), 0, 0, 0, 0, 1);
    wait_mem();
    ctl(bit_of(0), bit_of(7));
    ctl(0, 0, 0, 0, 0, 1);
    // R7 memory beats a bus load of MDR every cycle
    while (m_prd) ctl(bit_of(4), bit_of(7));
    expect_reg(7, v1, "R7 read back");
    // R9 read and write together: write dropped
    ctl(0, 0, 0, 0, 0, 1, 1);
    vectors++;
    if (mem_wr !== 1'b0) fail("R9 write dropped", 16'(mem_wr), 16'h0);
    ctl(0, 0, 0, 0, 0, 0, 1);
    wait_mem();
    // R10 stray completion
    out_en = 0; in_en = 0; rd_cmd = 0; wr_cmd = 0; stray = 1;
    step();
    expect_reg(7, mem[v0[7:0]], "R10 stray done");
    // random phase
    for (int k = 0; k < 600; k++) begin
      int s;
      logic [9:0] oe;
      s = $urandom % 12;
      oe = (s < 10) ? bit_of(s) : (s == 10 ? 10'h0 : bit_of($urandom % 5) | bit_of(5 + $urandom % 5));
      out_en = oe;
      in_en = 10'($urandom) & 10'($urandom);
      alu_sub = 1'($urandom); clear_y = 1'($urandom); carry_in = 1'($urandom);
      rd_cmd = ($urandom % 4) == 0; wr_cmd = ($urandom % 4) == 0;
      stray = ($urandom % 8) == 0;
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule